// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Arming Controller

This block keeps the receive-buffer state of the bulk OUT endpoints 1 to 7 of a USB device core. It decides, packet by packet, whether incoming OUT data is taken into an endpoint buffer, refused with NAK, or left unanswered. The serial engine in front of it reports the OUT token, a strobe per data byte, the end of the data packet with its CRC verdict, and the data PID (DATA0 or DATA1). The block answers with a one-cycle ACK or NAK pulse and drives a write enable for each of the eight buffers. The buffer RAM and the CRC logic are outside the block.

On the processor side, software sees a busy bit and an interrupt request bit per endpoint. Writing an endpoint's byte-count register with any value hands the buffer back to USB. Interrupt bits are cleared by writing ones. A pairing register can merge endpoints 2/3, 4/5 or 6/7 into one double-buffered endpoint. Software then works only through the even endpoint, and the two buffers are filled and released in turn.

Top module: `usb_out_arm_ctrl`

## Requirements
- R1: After `rst_n` is released, and in the cycle after a `bus_reset` pulse, every unpaired endpoint 1..7 shows busy = 1, all interrupt bits are 0, every expected toggle is DATA0, and no handshake is pending. A `bus_reset` leaves the pairing register unchanged.
- R2: A good packet that reaches an endpoint with no free buffer is answered by `hs_nak` high for one cycle, starting one cycle after `pkt_end`. During its bytes, `buf_we` stays 0 and the endpoint state does not change.
- R3: A `cpu_bc_wr` pulse naming a single-mode endpoint sets its busy bit again, whatever the written value. The next good packet for that endpoint is accepted.
- R4: A packet that ends with `pkt_crc_ok` = 0 gets no handshake and changes no busy bit, interrupt bit or toggle.
- R5: A good packet whose data PID matches the expected toggle, sent to an endpoint with a free buffer, is accepted. `hs_ack` is high for one cycle, starting one cycle after `pkt_end`. Busy goes to 0 and the interrupt bit goes to 1. During the bytes, only that buffer's bit of `buf_we` (bit n = buffer n) is high.
- R6: Each endpoint has its own expected toggle (`pkt_data1` = 0 means DATA0). The toggle flips only on acceptance. A good packet with the wrong PID is acknowledged but not committed: busy and the interrupt bit stay as they were.
- R7: In `cpu_pair_data`, bit 3 pairs 2/3, bit 4 pairs 4/5 and bit 5 pairs 6/7. Bits 2..0 have no effect on this block.
- R8: While a pair is enabled, the odd endpoint's busy and interrupt bits read 0. Its byte-count writes and interrupt clears are ignored, and OUT packets addressed to it get no handshake.
- R9: A paired endpoint takes packets alternately into the even buffer and then the odd buffer, starting with the even one. Busy reads 0 while either buffer holds data, and NAK is given only when both are full. Each byte-count write to the even endpoint releases the oldest full buffer, and `pair_rd_odd` shows which buffer software reads next.
- R10: `cpu_irq_clr_wr` clears the interrupt bits whose mask bit is 1 and leaves the others alone. A new acceptance in the same cycle wins over the clear.
- R11: If a byte-count write and an acceptance for the same single-mode endpoint fall in the same cycle, the endpoint ends armed (busy = 1), and the packet is still acknowledged.
- R12: OUT packets for endpoint 0, or for any number above 7, get no handshake and raise no `buf_we`. Endpoint 0's busy and interrupt bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| bus_reset | input | 1 | USB bus reset seen on the wire, synchronous pulse |
| tok_valid | input | 1 | OUT token received this cycle |
| tok_ep | input | EP_W | Endpoint number carried by the token |
| pkt_byte_valid | input | 1 | One data byte of the current packet this cycle |
| pkt_end | input | 1 | Data packet finished this cycle |
| pkt_crc_ok | input | 1 | CRC verdict, valid with `pkt_end` |
| pkt_data1 | input | 1 | Data PID was DATA1, valid with `pkt_end` |
| cpu_bc_wr | input | 1 | Processor write to an OUT byte-count register |
| cpu_bc_ep | input | 3 | Endpoint of that byte-count register |
| cpu_irq_clr_wr | input | 1 | Processor write-one-to-clear of interrupt bits |
| cpu_irq_clr_mask | input | 8 | Bits to clear, bit n = endpoint n |
| cpu_pair_wr | input | 1 | Processor write to the pairing register |
| cpu_pair_data | input | 6 | New pairing register value |
| hs_ack | output | 1 | Send ACK handshake |
| hs_nak | output | 1 | Send NAK handshake |
| buf_we | output | 8 | Buffer write enable, bit n = buffer n |
| ep_busy | output | 8 | Busy bit per endpoint |
| ep_irq | output | 8 | Interrupt request per endpoint |
| pair_rd_odd | output | 4 | Per pair k (endpoints 2k, 2k+1): software reads the odd buffer next |

## Verification
The bench builds the block with `EP_W` = 4, so the token field can carry endpoint numbers 8 to 15. This lets the bench send packets that the block must leave unanswered, beside endpoint 0. With that width, a single run also covers the single-buffer arm/accept/NAK cycle, CRC and toggle failures, the same-cycle arm and accept race, and the fill-and-release order of a paired endpoint through `buf_we` and `pair_rd_odd`. It also checks which pairing bits are decoded and that a bus reset rearms every endpoint.

// File: rtl/uoa_pkg.sv
package uoa_pkg;
  localparam int NUM_EP    = 8;
  localparam int NUM_PAIR  = NUM_EP / 2;
  localparam int EP_IDX_W  = $clog2(NUM_EP);
  localparam int PAIR_W    = 6;

  // position of the OUT pairing bit for pair k (endpoints 2k and 2k+1)
  function automatic int pair_cfg_bit(input int k);
    return k + 2;
  endfunction

  function automatic logic [NUM_EP-1:0] ep_onehot(input logic [EP_IDX_W-1:0] i);
    return {{(NUM_EP-1){1'b0}}, 1'b1} << i;
  endfunction
endpackage

// File: rtl/uoa_token_latch.sv
module uoa_token_latch #(
  parameter int EP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            tok_valid,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            pkt_end,
  output logic [EP_W-1:0] cur_ep,
  output logic            cur_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ep    <= '0;
      cur_valid <= 1'b0;
    end else if (bus_reset) begin
      cur_ep    <= '0;
      cur_valid <= 1'b0;
    end else if (tok_valid) begin
      cur_ep    <= tok_ep;
      cur_valid <= 1'b1;
    end else if (pkt_end) begin
      cur_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/uoa_pair_slot.sv
module uoa_pair_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic paired,
  input  logic acc_e,
  input  logic acc_o,
  input  logic bc_e,
  input  logic bc_o,
  input  logic clr_e,
  input  logic clr_o,
  output logic can_e,
  output logic can_o,
  output logic tog_e,
  output logic tog_o,
  output logic busy_e,
  output logic busy_o,
  output logic irq_e,
  output logic irq_o,
  output logic wsel_odd,
  output logic rd_odd
);
  logic [1:0] full, full_n;
  logic [1:0] tog, tog_n;
  logic [1:0] irq, irq_n;
  logic       wptr, wptr_n;
  logic       rptr, rptr_n;

  always_comb begin
    full_n = full;
    tog_n  = tog;
    irq_n  = irq;
    wptr_n = wptr;
    rptr_n = rptr;
    if (paired) begin
      if (acc_e) begin
        full_n[wptr] = 1'b1;
        wptr_n       = ~wptr;
        tog_n[0]     = ~tog[0];
      end
      if (bc_e && full[rptr]) begin
        full_n[rptr] = 1'b0;
        rptr_n       = ~rptr;
      end
      irq_n[0] = (irq[0] & ~clr_e) | acc_e;
      irq_n[1] = 1'b0;
    end else begin
      // acceptance first, byte-count arm last
      full_n[0] = (full[0] | acc_e) & ~bc_e;
      full_n[1] = (full[1] | acc_o) & ~bc_o;
      if (acc_e) tog_n[0] = ~tog[0];
      if (acc_o) tog_n[1] = ~tog[1];
      irq_n[0] = (irq[0] & ~clr_e) | acc_e;
      irq_n[1] = (irq[1] & ~clr_o) | acc_o;
      wptr_n   = 1'b0;
      rptr_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0;
      tog  <= '0;
      irq  <= '0;
      wptr <= 1'b0;
      rptr <= 1'b0;
    end else if (bus_reset) begin
      full <= '0;
      tog  <= '0;
      irq  <= '0;
      wptr <= 1'b0;
      rptr <= 1'b0;
    end else begin
      full <= full_n;
      tog  <= tog_n;
      irq  <= irq_n;
      wptr <= wptr_n;
      rptr <= rptr_n;
    end
  end

  assign can_e    = paired ? ~full[wptr] : ~full[0];
  assign can_o    = ~paired & ~full[1];
  assign tog_e    = tog[0];
  assign tog_o    = tog[1];
  assign busy_e   = paired ? ~(full[0] | full[1]) : ~full[0];
  assign busy_o   = ~paired & ~full[1];
  assign irq_e    = irq[0];
  assign irq_o    = ~paired & irq[1];
  assign wsel_odd = wptr;
  assign rd_odd   = paired & rptr;
endmodule

// File: rtl/usb_out_arm_ctrl.sv
module usb_out_arm_ctrl
  import uoa_pkg::*;
#(
  parameter int EP_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_reset,
  input  logic                tok_valid,
  input  logic [EP_W-1:0]     tok_ep,
  input  logic                pkt_byte_valid,
  input  logic                pkt_end,
  input  logic                pkt_crc_ok,
  input  logic                pkt_data1,
  input  logic                cpu_bc_wr,
  input  logic [EP_IDX_W-1:0] cpu_bc_ep,
  input  logic                cpu_irq_clr_wr,
  input  logic [NUM_EP-1:0]   cpu_irq_clr_mask,
  input  logic                cpu_pair_wr,
  input  logic [PAIR_W-1:0]   cpu_pair_data,
  output logic                hs_ack,
  output logic                hs_nak,
  output logic [NUM_EP-1:0]   buf_we,
  output logic [NUM_EP-1:0]   ep_busy,
  output logic [NUM_EP-1:0]   ep_irq,
  output logic [NUM_PAIR-1:0] pair_rd_odd
);
  logic [EP_W-1:0]     cur_ep;
  logic                cur_valid;
  logic [PAIR_W-1:0]   pair_cfg;
  logic [NUM_PAIR-1:0] paired, wsel;
  logic [NUM_EP-1:0]   can_acc, exp_tog, busy_raw, irq_raw;
  logic [NUM_EP-1:0]   acc_vec, bc_vec, clr_vec;
  logic                hi_zero, ep_known, valid_ep, slot_can, tog_match;
  logic [EP_IDX_W-1:0] idx, tgt_buf;
  logic [EP_IDX_W-2:0] pk;
  // named internal events, observed by the checker
  logic                pkt_good, pkt_accept, pkt_nak, pkt_dup;
  logic                unused_bits;

  uoa_token_latch #(.EP_W(EP_W)) u_tok (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .pkt_end(pkt_end),
    .cur_ep(cur_ep), .cur_valid(cur_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pair_cfg <= '0;
    else if (cpu_pair_wr) pair_cfg <= cpu_pair_data;
  end

  // token field wider than the endpoint index: upper bits must be zero
  if (EP_W > EP_IDX_W) begin : g_wide
    assign hi_zero = ~|cur_ep[EP_W-1:EP_IDX_W];
  end else begin : g_narrow
    assign hi_zero = 1'b1;
  end

  assign idx       = cur_ep[EP_IDX_W-1:0];
  assign pk        = idx[EP_IDX_W-1:1];
  assign ep_known  = cur_valid && hi_zero && (idx != '0);
  assign valid_ep  = ep_known && !(idx[0] && paired[pk]);
  assign slot_can  = can_acc[idx];
  assign tog_match = (pkt_data1 == exp_tog[idx]);
  assign tgt_buf   = paired[pk] ? {pk, wsel[pk]} : idx;

  assign pkt_good   = pkt_end && valid_ep && pkt_crc_ok;
  assign pkt_nak    = pkt_good && !slot_can;
  assign pkt_dup    = pkt_good && slot_can && !tog_match;
  assign pkt_accept = pkt_good && slot_can && tog_match;

  assign acc_vec = pkt_accept ? ep_onehot(idx) : '0;
  assign bc_vec  = cpu_bc_wr ? ep_onehot(cpu_bc_ep) : '0;
  assign clr_vec = cpu_irq_clr_wr ? cpu_irq_clr_mask : '0;
  assign buf_we  = (pkt_byte_valid && valid_ep && slot_can) ? ep_onehot(tgt_buf) : '0;

  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    if (k == 0) begin : g_fixed
      assign paired[k] = 1'b0;
    end else begin : g_cfg
      assign paired[k] = pair_cfg[pair_cfg_bit(k)];
    end
    uoa_pair_slot u_slot (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .paired(paired[k]),
      .acc_e(acc_vec[2*k]), .acc_o(acc_vec[2*k+1]),
      .bc_e(bc_vec[2*k]),   .bc_o(bc_vec[2*k+1]),
      .clr_e(clr_vec[2*k]), .clr_o(clr_vec[2*k+1]),
      .can_e(can_acc[2*k]), .can_o(can_acc[2*k+1]),
      .tog_e(exp_tog[2*k]), .tog_o(exp_tog[2*k+1]),
      .busy_e(busy_raw[2*k]), .busy_o(busy_raw[2*k+1]),
      .irq_e(irq_raw[2*k]), .irq_o(irq_raw[2*k+1]),
      .wsel_odd(wsel[k]), .rd_odd(pair_rd_odd[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_ack <= 1'b0;
      hs_nak <= 1'b0;
    end else if (bus_reset) begin
      hs_ack <= 1'b0;
      hs_nak <= 1'b0;
    end else begin
      hs_ack <= pkt_accept | pkt_dup;
      hs_nak <= pkt_nak;
    end
  end

  assign ep_busy     = {busy_raw[NUM_EP-1:1], 1'b0};
  assign ep_irq      = irq_raw;
  assign unused_bits = ^{pair_cfg[2:0], busy_raw[0]};
endmodule

// File: rtl/uoa_checker.sv
module uoa_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       pkt_end,
  input logic       hs_ack,
  input logic       hs_nak,
  input logic [7:0] buf_we,
  input logic [7:0] ep_busy,
  input logic [7:0] ep_irq,
  input logic [7:0] acc_vec,
  input logic [5:0] pair_cfg,
  input logic       cpu_bc_wr,
  input logic [2:0] cpu_bc_ep
);
  AST_HS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(hs_ack && hs_nak)); // R2
  AST_HS_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) (hs_ack || hs_nak) |-> $past(pkt_end)); // R5
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(buf_we)); // R9
  AST_ACCEPT_IRQ: assert property (@(posedge clk) disable iff (!rst_n) ((|acc_vec) && !bus_reset) |=> ((ep_irq & $past(acc_vec)) == $past(acc_vec))); // R5
  AST_EP1_DISARM: assert property (@(posedge clk) disable iff (!rst_n) (acc_vec[1] && !bus_reset && !(cpu_bc_wr && cpu_bc_ep == 3'd1)) |=> !ep_busy[1]); // R5
  AST_SAME_CYCLE_ARM: assert property (@(posedge clk) disable iff (!rst_n) (acc_vec[1] && !bus_reset && cpu_bc_wr && cpu_bc_ep == 3'd1) |=> ep_busy[1]); // R11
  AST_BUS_RESET_ARMS: assert property (@(posedge clk) disable iff (!rst_n) bus_reset |=> (ep_busy[1] && ep_irq == 8'h00 && !hs_ack && !hs_nak)); // R1
  AST_PAIR67_ODD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) pair_cfg[5] |-> (!ep_busy[7] && !ep_irq[7])); // R8
  AST_EP0_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (!ep_busy[0] && !buf_we[0] && !ep_irq[0])); // R12
endmodule

bind usb_out_arm_ctrl uoa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .pkt_end(pkt_end),
  .hs_ack(hs_ack), .hs_nak(hs_nak), .buf_we(buf_we), .ep_busy(ep_busy),
  .ep_irq(ep_irq), .acc_vec(acc_vec), .pair_cfg(pair_cfg),
  .cpu_bc_wr(cpu_bc_wr), .cpu_bc_ep(cpu_bc_ep)
);

// File: tb/usb_out_arm_ctrl_test.sv
`timescale 1ns/1ps
module usb_out_arm_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       tok_valid = 1'b0;
  logic [3:0] tok_ep = '0;
  logic       pkt_byte_valid = 1'b0;
  logic       pkt_end = 1'b0;
  logic       pkt_crc_ok = 1'b0;
  logic       pkt_data1 = 1'b0;
  logic       cpu_bc_wr = 1'b0;
  logic [2:0] cpu_bc_ep = '0;
  logic       cpu_irq_clr_wr = 1'b0;
  logic [7:0] cpu_irq_clr_mask = '0;
  logic       cpu_pair_wr = 1'b0;
  logic [5:0] cpu_pair_data = '0;
  logic       hs_ack, hs_nak;
  logic [7:0] buf_we, ep_busy, ep_irq;
  logic [3:0] pair_rd_odd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  usb_out_arm_ctrl #(.EP_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .pkt_byte_valid(pkt_byte_valid),
    .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .pkt_data1(pkt_data1),
    .cpu_bc_wr(cpu_bc_wr), .cpu_bc_ep(cpu_bc_ep),
    .cpu_irq_clr_wr(cpu_irq_clr_wr), .cpu_irq_clr_mask(cpu_irq_clr_mask),
    .cpu_pair_wr(cpu_pair_wr), .cpu_pair_data(cpu_pair_data),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .buf_we(buf_we),
    .ep_busy(ep_busy), .ep_irq(ep_irq), .pair_rd_odd(pair_rd_odd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // token, three bytes, then packet end; results read one cycle after the end
  task automatic send_pkt(input int ep, input bit d1, input bit crc,
                          input bit bc_same, input int bc_ep_same,
                          output bit ack, output bit nak, output logic [7:0] wem);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_ep    = 4'(ep);
    @(negedge clk);
    tok_valid = 1'b0;
    wem = '0;
    for (int i = 0; i < 3; i++) begin
      pkt_byte_valid = 1'b1;
      #1 wem |= buf_we;
      @(negedge clk);
    end
    pkt_byte_valid = 1'b0;
    pkt_end    = 1'b1;
    pkt_crc_ok = crc;
    pkt_data1  = d1;
    if (bc_same) begin
      cpu_bc_wr = 1'b1;
      cpu_bc_ep = 3'(bc_ep_same);
    end
    @(negedge clk);
    ack = hs_ack;
    nak = hs_nak;
    pkt_end   = 1'b0;
    cpu_bc_wr = 1'b0;
  endtask

  task automatic bc_write(input int ep);
    @(negedge clk);
    cpu_bc_wr = 1'b1;
    cpu_bc_ep = 3'(ep);
    @(negedge clk);
    cpu_bc_wr = 1'b0;
  endtask

  task automatic irq_clear(input logic [7:0] mask);
    @(negedge clk);
    cpu_irq_clr_wr   = 1'b1;
    cpu_irq_clr_mask = mask;
    @(negedge clk);
    cpu_irq_clr_wr = 1'b0;
  endtask

  task automatic pair_write(input logic [5:0] v);
    @(negedge clk);
    cpu_pair_wr   = 1'b1;
    cpu_pair_data = v;
    @(negedge clk);
    cpu_pair_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 busy after reset", ep_busy, 8'hFE);
    check("R1 irq after reset", ep_irq, 8'h00);
    check("R1 no handshake after reset", {hs_ack, hs_nak}, 2'b00);
  endtask

  task automatic t_single_cycle();
    bit a, n; logic [7:0] w;
    send_pkt(1, 1'b0, 1'b1, 1'b0, 0, a, n, w);
    check("R5 ack on accept", {a, n}, 2'b10);
    check("R5 buf_we ep1", w, 8'h02);
    check("R5 busy cleared", ep_busy[1], 1'b0);
    check("R5 irq raised", ep_irq[1], 1'b1);
    send_pkt(1, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R2 nak when full", {a, n}, 2'b01);
    check("R2 no write when full", w, 8'h00);
    check("R2 busy unchanged", ep_busy[1], 1'b0);
    irq_clear(8'h02);
    check("R10 irq cleared", ep_irq[1], 1'b0);
    bc_write(1);
    check("R3 rearm sets busy", ep_busy[1], 1'b1);
    send_pkt(1, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R3 next packet accepted", {a, n, ep_busy[1]}, 3'b100);
  endtask

  task automatic t_crc_fail();
    bit a, n; logic [7:0] w;
    send_pkt(5, 1'b0, 1'b0, 1'b0, 0, a, n, w);
    check("R4 no handshake on bad crc", {a, n}, 2'b00);
    check("R4 state kept on bad crc", {ep_busy[5], ep_irq[5]}, 2'b10);
    send_pkt(5, 1'b0, 1'b1, 1'b0, 0, a, n, w);
    check("R4 toggle kept, retry accepted", {a, ep_irq[5], ep_busy[5]}, 3'b110);
  endtask

  task automatic t_toggle();
    bit a, n; logic [7:0] w;
    send_pkt(2, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R6 mismatch acked", {a, n}, 2'b10);
    check("R6 mismatch not committed", {ep_busy[2], ep_irq[2]}, 2'b10);
    send_pkt(2, 1'b0, 1'b1, 1'b0, 0, a, n, w);
    check("R6 matching PID committed", {a, ep_busy[2], ep_irq[2]}, 3'b101);
    bc_write(2);
    irq_clear(8'h04);
    // R10: clearing ep2 leaves ep5 pending
    check("R10 other irq untouched", {ep_irq[5], ep_irq[2]}, 2'b10);
  endtask

  task automatic t_invalid();
    bit a, n; logic [7:0] w;
    send_pkt(0, 1'b0, 1'b1, 1'b0, 0, a, n, w);
    check("R12 ep0 silent", {a, n, w}, 10'h000);
    send_pkt(9, 1'b0, 1'b1, 1'b0, 0, a, n, w);
    check("R12 ep9 silent", {a, n, w}, 10'h000);
    bc_write(0);
    check("R12 ep0 busy stays 0", ep_busy[0], 1'b0);
  endtask

  task automatic t_in_bits();
    bit a, n; logic [7:0] w;
    pair_write(6'b000111);
    check("R7 IN bits leave ep3 single", ep_busy[3], 1'b1);
    send_pkt(3, 1'b0, 1'b1, 1'b0, 0, a, n, w);
    check("R7 ep3 accepted unpaired", {a, n, w}, 10'h208);
    bc_write(3);
  endtask

  task automatic t_paired();
    bit a, n; logic [7:0] w;
    pair_write(6'b001000);
    check("R8 odd busy reads 0", {ep_busy[3], ep_busy[2]}, 2'b01);
    // ep2 expected toggle is DATA1 here
    send_pkt(2, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R9 first fill even buffer", {a, w}, 9'h104);
    check("R9 busy 0 irq 1", {ep_busy[2], ep_irq[2]}, 2'b01);
    send_pkt(2, 1'b0, 1'b1, 1'b0, 0, a, n, w);
    check("R9 second fill odd buffer", {a, w}, 9'h108);
    send_pkt(2, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R9 nak when both full", {a, n, w}, 10'h100);
    send_pkt(3, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R8 odd token silent", {a, n, w}, 10'h000);
    bc_write(3);
    send_pkt(2, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R8 odd bc ignored", {a, n}, 2'b01);
    irq_clear(8'h08);
    check("R8 odd clear ignored", {ep_irq[3], ep_irq[2]}, 2'b01);
    check("R9 read even first", pair_rd_odd[1], 1'b0);
    bc_write(2);
    check("R9 one released busy 0", {ep_busy[2], pair_rd_odd[1]}, 2'b01);
    send_pkt(2, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R9 refill even buffer", {a, w}, 9'h104);
    bc_write(2);
    check("R9 second release", {ep_busy[2], pair_rd_odd[1]}, 2'b00);
    bc_write(2);
    check("R9 all released busy 1", {ep_busy[2], pair_rd_odd[1]}, 2'b11);
    pair_write(6'b111000);
    check("R7 bit5 pairs 6/7", ep_busy[7], 1'b0);
    send_pkt(5, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R7 bit4 pairs 4/5", {a, n, w}, 10'h000);
    pair_write(6'b000000);
  endtask

  task automatic t_same_cycle();
    bit a, n; logic [7:0] w;
    send_pkt(4, 1'b0, 1'b1, 1'b1, 4, a, n, w);
    check("R11 acked with same-cycle arm", {a, n}, 2'b10);
    check("R11 armed after", {ep_busy[4], ep_irq[4]}, 2'b11);
    send_pkt(4, 1'b1, 1'b1, 1'b0, 0, a, n, w);
    check("R11 next accepted", {a, ep_busy[4]}, 2'b10);
  endtask

  task automatic t_bus_reset();
    bit a, n; logic [7:0] w;
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    check("R1 busy after bus reset", ep_busy, 8'hFE);
    check("R1 irq after bus reset", ep_irq, 8'h00);
    // ep5 expected DATA1 before reset; DATA0 must now be accepted
    send_pkt(5, 1'b0, 1'b1, 1'b0, 0, a, n, w);
    check("R1 toggle back to DATA0", {a, ep_busy[5], ep_irq[5]}, 3'b101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_single_cycle();
    t_crc_fail();
    t_toggle();
    t_invalid();
    t_in_bits();
    t_paired();
    t_same_cycle();
    t_bus_reset();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule